// File: doc/BRIEF.md
# TDM Channel Strobe and Chip-Select Generator

This block produces the parallel-bus timing for a controller that moves bytes between a 32-channel serial time-division stream and a shared parallel memory bus. It counts clocks from a frame pulse and always knows the current channel and the clock position within that channel. Each channel lasts 16 clocks: 8 serial bits, most significant bit first, at two clocks per bit. From that position it drives a 5-bit channel address onto the bus.

Each channel is split into two halves. The first device on the bus receives a channel strobe in the first half. A second device receives a delayed chip select in the second half. Both devices share one set of address, data, read-enable and write-enable lines. Inside each half, a read-enable pulse comes before a write-enable pulse. The first clock of each half is left idle. This gives the address one clock of setup before any strobe.

The timing outputs are produced only while the parallel-controller mode input is high. With the mode input low, the address reads zero and every strobe stays inactive. The counters keep running in that state, so the block stays aligned to the frame.

Top module: `tdm_strobe_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it, the position is channel 0, clock 0. `chan_addr` is 0 and all four active-low strobes are high.
- R2: Without a frame pulse, the clock position (0 to 15) advances by one every clock. The channel advances by one when the position wraps from 15 to 0, and channel 31 is followed by channel 0. One frame is therefore 512 clocks.
- R3: When `frame_n` is sampled low at a rising edge, the next cycle is channel 0, clock 0, whatever the previous position was.
- R4: While the mode input is high, `chan_addr` changes only in a cycle whose clock position is 0.
- R5: `chan_stb_n` is low exactly at clock positions 1 to 7 of each channel while the mode input is high.
- R6: `dly_cs_n` is low exactly at clock positions 9 to 15 of each channel while the mode input is high.
- R7: `chan_stb_n` and `dly_cs_n` are never low in the same cycle.
- R8: `oe_n` is low exactly at clock positions 1 to 3 and 9 to 11 while the mode input is high.
- R9: `we_n` is low exactly at clock positions 5 to 7 and 13 to 15 while the mode input is high. It is never low in the same cycle as `oe_n`.
- R10: While `ctrl_mode_en` is low, `chan_addr` is 0 and all strobes are high. The position keeps counting, so the outputs match the running position in the first cycle after the mode returns high.
- R11: `chan_addr` equals the current channel number (0 to 31) while the mode input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, two clocks per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_mode_en | input | 1 | High selects the 32-channel parallel-controller mode |
| frame_n | input | 1 | Active-low frame pulse; realigns the counters to channel 0, clock 0 |
| chan_addr | output | 5 | Current channel number on the shared address bus |
| chan_stb_n | output | 1 | Active-low first-half strobe; chip select of the first device |
| dly_cs_n | output | 1 | Active-low second-half chip select for the daisy-chained device |
| oe_n | output | 1 | Active-low read enable, early part of each half |
| we_n | output | 1 | Active-low write enable, late part of each half |

## Verification
The bench computes the expected channel and clock position and compares every output against it in every cycle. It first sweeps two complete frames after a single frame pulse. This separates a correct 31-to-0 channel wrap and 15-to-0 position wrap from an off-by-one in either counter. A second frame pulse arrives in the middle of a channel, which shows that realignment ignores the current position. A long stretch with the mode input low, followed by re-enabling, distinguishes output gating from counter gating: a design that stopped its counters would return with the wrong channel.

// File: rtl/tdm_strobe_pkg.sv
package tdm_strobe_pkg;

    parameter int CH_COUNT     = 32;
    parameter int BITS_PER_CH  = 8;
    parameter int CLKS_PER_BIT = 2;

    localparam int CLKS_PER_CH = BITS_PER_CH * CLKS_PER_BIT;
    localparam int HALF_LEN    = CLKS_PER_CH / 2;
    localparam int ADDR_W      = $clog2(CH_COUNT);
    localparam int PH_W        = $clog2(CLKS_PER_CH);
    localparam int OFF_W       = $clog2(HALF_LEN);
    localparam int RD_LAST     = HALF_LEN / 2 - 1;
    localparam int WR_FIRST    = HALF_LEN / 2 + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] chan;
        logic [PH_W-1:0]   phase;
    } slot_pos_t;

    typedef struct packed {
        logic stb;
        logic dly;
        logic rd;
        logic wr;
    } bus_ctl_t;

    function automatic logic off_in(input logic [OFF_W-1:0] off,
                                    input int lo, input int hi);
        return (int'(off) >= lo) && (int'(off) <= hi);
    endfunction

endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter
    import tdm_strobe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      frame_n,
    output slot_pos_t pos
);

    localparam logic [PH_W-1:0]   PH_LAST = PH_W'(CLKS_PER_CH - 1);
    localparam logic [ADDR_W-1:0] CH_LAST = ADDR_W'(CH_COUNT - 1);

    slot_pos_t pos_nxt;

    always_comb begin
        pos_nxt = pos;
        if (!frame_n) begin
            pos_nxt = '0;
        end else if (pos.phase == PH_LAST) begin
            pos_nxt.phase = '0;
            pos_nxt.chan  = (pos.chan == CH_LAST) ? '0 : pos.chan + 1'b1;
        end else begin
            pos_nxt.phase = pos.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pos <= '0;
        else     pos <= pos_nxt;
    end

endmodule

// File: rtl/tdm_window_decode.sv
module tdm_window_decode
    import tdm_strobe_pkg::*;
(
    input  slot_pos_t pos,
    output bus_ctl_t  ctl
);

    logic             hsel;
    logic [OFF_W-1:0] off;
    logic [1:0]       win_h, rd_h, wr_h;

    assign hsel = pos.phase[PH_W-1];
    assign off  = pos.phase[OFF_W-1:0];

    for (genvar g = 0; g < 2; g++) begin : g_half
        logic here;
        assign here    = (hsel == 1'(g));
        assign win_h[g] = here && off_in(off, 1, HALF_LEN - 1);
        assign rd_h[g]  = here && off_in(off, 1, RD_LAST);
        assign wr_h[g]  = here && off_in(off, WR_FIRST, HALF_LEN - 1);
    end

    always_comb begin
        ctl.stb = win_h[0];
        ctl.dly = win_h[1];
        ctl.rd  = |rd_h;
        ctl.wr  = |wr_h;
    end

endmodule

// File: rtl/tdm_bus_drive.sv
module tdm_bus_drive
    import tdm_strobe_pkg::*;
(
    input  logic              mode_en,
    input  slot_pos_t         pos,
    input  bus_ctl_t          ctl,
    output logic [ADDR_W-1:0] addr,
    output logic              stb_n,
    output logic              dly_n,
    output logic              rd_n,
    output logic              wr_n
);

    always_comb begin
        addr  = mode_en ? pos.chan : '0;
        stb_n = !(mode_en && ctl.stb);
        dly_n = !(mode_en && ctl.dly);
        rd_n  = !(mode_en && ctl.rd);
        wr_n  = !(mode_en && ctl.wr);
    end

endmodule

// File: rtl/tdm_strobe_gen.sv
module tdm_strobe_gen
    import tdm_strobe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_mode_en,
    input  logic              frame_n,
    output logic [ADDR_W-1:0] chan_addr,
    output logic              chan_stb_n,
    output logic              dly_cs_n,
    output logic              oe_n,
    output logic              we_n
);

    slot_pos_t pos;
    bus_ctl_t  ctl;

    tdm_slot_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .frame_n (frame_n),
        .pos     (pos)
    );

    tdm_window_decode u_dec (
        .pos (pos),
        .ctl (ctl)
    );

    tdm_bus_drive u_drv (
        .mode_en (ctrl_mode_en),
        .pos     (pos),
        .ctl     (ctl),
        .addr    (chan_addr),
        .stb_n   (chan_stb_n),
        .dly_n   (dly_cs_n),
        .rd_n    (oe_n),
        .wr_n    (we_n)
    );

endmodule

// File: rtl/tdm_strobe_chk.sv
module tdm_strobe_chk
    import tdm_strobe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ctrl_mode_en,
    input logic              frame_n,
    input logic [ADDR_W-1:0] chan_addr,
    input logic              chan_stb_n,
    input logic              dly_cs_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] pos_chan,
    input logic [PH_W-1:0]   pos_phase
);

    localparam logic [PH_W-1:0]   PH_LAST = PH_W'(CLKS_PER_CH - 1);
    localparam logic [ADDR_W-1:0] CH_LAST = ADDR_W'(CH_COUNT - 1);

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (chan_addr == '0 && chan_stb_n && dly_cs_n && oe_n && we_n)); // R1

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (frame_n && pos_phase != PH_LAST) |=>
        (pos_phase == $past(pos_phase) + 1'b1 && pos_chan == $past(pos_chan))); // R2

    AST_CHAN_WRAP: assert property (@(posedge clk) disable iff (rst)
        (frame_n && pos_phase == PH_LAST) |=>
        (pos_phase == '0 &&
         pos_chan == (($past(pos_chan) == CH_LAST) ? '0 : $past(pos_chan) + 1'b1))); // R2

    AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (rst)
        !frame_n |=> (pos_chan == '0 && pos_phase == '0)); // R3

    AST_ADDR_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (ctrl_mode_en && $past(ctrl_mode_en) && !$stable(chan_addr)) |-> (pos_phase == '0)); // R4

    AST_STB_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !chan_stb_n |-> (ctrl_mode_en && pos_phase >= PH_W'(1) && pos_phase < PH_W'(HALF_LEN))); // R5

    AST_DLY_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !dly_cs_n |-> (ctrl_mode_en && pos_phase > PH_W'(HALF_LEN))); // R6

    AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(!chan_stb_n && !dly_cs_n)); // R7

    AST_RD_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (int'(pos_phase[OFF_W-1:0]) >= 1 && int'(pos_phase[OFF_W-1:0]) <= RD_LAST)); // R8

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $countones({oe_n, we_n}) >= 1); // R9

    AST_MODE_OFF: assert property (@(posedge clk) disable iff (rst)
        !ctrl_mode_en |-> (chan_addr == '0 && chan_stb_n && dly_cs_n && oe_n && we_n)); // R10

    AST_ADDR_CHAN: assert property (@(posedge clk) disable iff (rst)
        ctrl_mode_en |-> (chan_addr == pos_chan)); // R11

endmodule

bind tdm_strobe_gen tdm_strobe_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .ctrl_mode_en (ctrl_mode_en),
    .frame_n      (frame_n),
    .chan_addr    (chan_addr),
    .chan_stb_n   (chan_stb_n),
    .dly_cs_n     (dly_cs_n),
    .oe_n         (oe_n),
    .we_n         (we_n),
    .pos_chan     (pos.chan),
    .pos_phase    (pos.phase)
);

// File: tb/tdm_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module tdm_strobe_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m   = 1'b1;
    logic       frame_n = 1'b1;
    logic [4:0] chan_addr;
    logic       chan_stb_n, dly_cs_n, oe_n, we_n;

    int n_chk  = 0;
    int n_fail = 0;
    int ech    = 0;
    int eph    = 0;
    int prev_addr = 0;
    logic prev_m  = 1'b0;
    bit   done    = 1'b0;

    always #5 clk = ~clk;

    tdm_strobe_gen dut_i (
        .clk          (clk),
        .rst          (rst),
        .ctrl_mode_en (m),
        .frame_n      (frame_n),
        .chan_addr    (chan_addr),
        .chan_stb_n   (chan_stb_n),
        .dly_cs_n     (dly_cs_n),
        .oe_n         (oe_n),
        .we_n         (we_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (chan %0d pos %0d)",
                     tag, act, exp, ech, eph);
        end
    endtask

    task automatic check_all(input string tag);
        int off;
        int e_stb, e_dly, e_rd, e_wr, e_addr;
        off    = eph % 8;
        e_addr = m ? ech : 0;
        e_stb  = (m && eph >= 1 && eph <= 7) ? 0 : 1;
        e_dly  = (m && eph >= 9 && eph <= 15) ? 0 : 1;
        e_rd   = (m && off >= 1 && off <= 3) ? 0 : 1;
        e_wr   = (m && off >= 5 && off <= 7) ? 0 : 1;
        chk({tag, " R11 address"}, int'(chan_addr), e_addr);
        chk({tag, " R5 chan_stb_n"}, int'(chan_stb_n), e_stb);
        chk({tag, " R6 dly_cs_n"}, int'(dly_cs_n), e_dly);
        chk({tag, " R8 oe_n"}, int'(oe_n), e_rd);
        chk({tag, " R9 we_n"}, int'(we_n), e_wr);
        chk("R7 both selects low", (!chan_stb_n && !dly_cs_n) ? 1 : 0, 0);
        chk("R9 oe and we both low", (!oe_n && !we_n) ? 1 : 0, 0);
        chk("R4 address change off boundary",
            (m && prev_m && int'(chan_addr) != prev_addr && eph != 0) ? 1 : 0, 0);
        prev_addr = int'(chan_addr);
        prev_m    = m;
    endtask

    task automatic step(input logic r, input logic f, input logic md, input string tag);
        rst = r; frame_n = f; m = md;
        @(posedge clk);
        if (r || !f) begin
            ech = 0; eph = 0;
        end else begin
            eph++;
            if (eph == 16) begin
                eph = 0;
                ech = (ech + 1) % 32;
            end
        end
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, "R1 reset");
        step(1'b0, 1'b1, 1'b1, "R1 first cycle after reset");
        // R2: free run then frame pulse, then two full frames
        for (int i = 0; i < 37; i++) step(1'b0, 1'b1, 1'b1, "R2 free run");
        step(1'b0, 1'b0, 1'b1, "R3 frame pulse");
        chk("R3 align channel", int'(chan_addr), 0);
        for (int i = 0; i < 2 * 512 + 5; i++) step(1'b0, 1'b1, 1'b1, "R2 frame sweep");
        // R3: realign from mid-channel
        while (!(ech == 13 && eph == 6)) step(1'b0, 1'b1, 1'b1, "R2 approach");
        step(1'b0, 1'b0, 1'b1, "R3 mid-channel pulse");
        chk("R3 realigned chan_stb_n idle", int'(chan_stb_n), 1);
        for (int i = 0; i < 100; i++) step(1'b0, 1'b1, 1'b1, "R3 after realign");
        // R10: mode off, counters keep running
        for (int i = 0; i < 700; i++) step(1'b0, 1'b1, 1'b0, "R10 mode off");
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 1'b1, "R10 mode back on");
        step(1'b0, 1'b0, 1'b0, "R10 pulse while off");
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b1, "R3 after pulse while off");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule